// File: doc/BRIEF.md
# CRC-guarded burst register target

This block is a small register bank that sits behind a byte-level serial bus front end. The front end has already handled bit timing and acknowledgement. It delivers each received byte with a valid strobe, and marks the first byte of a frame with a start strobe and the end of the frame with an end strobe. The first byte of a frame is the bus address byte: the 7-bit device address shifted left by one, with the direction in bit 0. The second byte is a command byte. It holds a 6-bit register address and a 2-bit burst length. A burst is one to four bytes and walks upward through consecutive register addresses.

Every transfer is protected by an 8-bit CRC.
- **Writes:** the CRC covers the address byte, the command byte and the data bytes. Data is held in a staging buffer and reaches the registers only when the CRC byte sent by the host matches the computed value. The host sends one trailing dummy byte after the CRC byte, and the block ignores it.
- **Reads:** the block answers straight after the command byte. It streams the requested registers and then a CRC byte computed over the address byte as received, the command byte and the returned data.

Three sticky flags report problems: a CRC mismatch, a frame cut short, and an access outside the populated part of the register space. A dedicated clear input resets all three flags.

Top module: `crc_reg_target`

## Requirements
- R1: After reset, every register reads as zero, `rd_vld` is low, and `crc_err`, `len_err` and `addr_err` are clear.
- R2: In the command byte, bits [5:0] give the start register address and bits [7:6] give the burst length. The codes 00, 01, 10 and 11 select 1, 2, 3 and 4 bytes. Byte k of a burst addresses register (start + k) modulo 64.
- R3: The CRC uses polynomial 0x07, processes bits MSB first and starts from 0x00. It runs over the address byte, then the command byte, then each data byte in order, and restarts at every frame start.
- R4: A write frame is: address byte, command byte, the data bytes, a CRC byte, then a dummy byte. When the CRC byte matches, the data is committed. The dummy byte and any later bytes in the same frame have no effect on the registers.
- R5: When the CRC byte of a write does not match, no register changes and `crc_err` is set. The flag stays set until `err_clr`.
- R6: A read frame is: address byte, command byte. Starting in the cycle after the command byte is accepted, `rd_vld` is high for length+1 consecutive cycles. During those cycles `rd_data` carries the register bytes in address order, followed by the CRC byte.
- R7: A write frame that ends (end strobe or a new frame start) before its CRC byte arrives is discarded and sets `len_err`. A read frame that ends before its command byte also sets `len_err`.
- R8: A burst that touches any register address at or above `NUM_REGS` sets `addr_err`. If it is a write, nothing is committed. If it is a read, no response is produced.
- R9: Pulsing `err_clr` clears all three error flags.
- R10: Bit 0 of the address byte selects the direction: 1 is a read, 0 is a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sof | input | 1 | Frame start; qualifies the byte presented with `byte_vld` in the same cycle |
| eof | input | 1 | Frame end strobe, given in a cycle without a byte |
| byte_vld | input | 1 | Received byte valid |
| byte_in | input | 8 | Received byte |
| err_clr | input | 1 | Clears all error flags |
| rd_vld | output | 1 | Response byte valid |
| rd_data | output | 8 | Response byte (data, then CRC) |
| crc_err | output | 1 | Sticky write CRC mismatch |
| len_err | output | 1 | Sticky short frame |
| addr_err | output | 1 | Sticky out-of-range burst |

## Verification
The assertions assume the following about the block's inputs:
- The front end never sends a received byte while a read response is being streamed.
- `eof` never coincides with a byte.
- `err_clr` is not raised in the same cycle as an error event.

The stimulus respects all three conditions. Every read frame waits six idle cycles before its end strobe, so the longest response (five bytes) has finished. End strobes and clear pulses are given in cycles of their own.

// File: rtl/crc_reg_pkg.sv
// Shared constants, frame states and the byte-wide CRC step function.
// Assumes the fixed frame layout: 6-bit register address, 2-bit length code.
package crc_reg_pkg;
    localparam int ADDR_W    = 6;
    localparam int MAX_BURST = 4;
    localparam int LEN_W     = $clog2(MAX_BURST);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_WDATA,
        ST_WCRC,
        ST_TX,
        ST_DONE
    } fstate_t;

    // Fold one byte into a CRC-8 value, MSB first.
    function automatic logic [7:0] crc8_step(input logic [7:0] c_in,
                                             input logic [7:0] d,
                                             input logic [7:0] poly);
        logic [7:0] c;
        c = c_in ^ d;
        for (int i = 0; i < 8; i++) begin
            c = c[7] ? ((c << 1) ^ poly) : (c << 1);
        end
        return c;
    endfunction
endpackage

// File: rtl/crc8_acc.sv
// Running CRC-8 accumulator: one byte per enabled cycle.
// Assumes clr marks the first byte of a frame; when clr and en coincide,
// that byte is folded into a zero seed.
module crc8_acc
    import crc_reg_pkg::*;
#(
    parameter logic [7:0] POLY = 8'h07
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic [7:0] din,
    output logic [7:0] crc
);
    logic [7:0] seed;

    // Pick the starting value: zero on frame start, else the running CRC.
    always_comb seed = clr ? 8'h00 : crc;

    // Update the accumulator on each enabled byte or frame restart.
    always_ff @(posedge clk) begin
        if (!rst_n)       crc <= 8'h00;
        else if (en)      crc <= crc8_step(seed, din, POLY);
        else if (clr)     crc <= 8'h00;
    end
endmodule

// File: rtl/reg_store.sv
// Register array with a one-cycle burst commit port and one read port.
// Assumes wr_en is only raised for bursts that lie fully below NUM_REGS.
module reg_store
    import crc_reg_pkg::*;
#(
    parameter int NUM_REGS = 40
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_base,
    input  logic [LEN_W-1:0]               wr_last,
    input  logic [MAX_BURST-1:0][7:0]      wr_data,
    input  logic [ADDR_W-1:0]              rd_addr,
    output logic [7:0]                     rd_data
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [NUM_REGS-1:0][7:0] mem;
    logic [NUM_REGS-1:0][7:0] mem_nxt;

    // Build the next array contents from a committed burst.
    always_comb begin
        logic [ADDR_W-1:0] a;
        mem_nxt = mem;
        for (int k = 0; k < MAX_BURST; k++) begin
            a = wr_base + ADDR_W'(k);
            if (wr_en && k <= int'(wr_last) && int'(a) < NUM_REGS)
                mem_nxt[a[IDX_W-1:0]] = wr_data[k];
        end
    end

    // Hold the array; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) mem <= '0;
        else        mem <= mem_nxt;
    end

    // Return the addressed register, zero beyond the populated range.
    always_comb rd_data = (int'(rd_addr) < NUM_REGS) ? mem[rd_addr[IDX_W-1:0]] : 8'h00;

    // R5
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mem));

    // R8
    commit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (NUM_REGS >= 64) || (int'(wr_base) + int'(wr_last) < NUM_REGS));
endmodule

// File: rtl/crc_reg_target.sv
// Frame decoder for CRC-guarded burst register access.
// Assumes bytes arrive pre-framed by a bus front end: sof flags the first
// byte, eof comes in a byte-free cycle, and no bytes arrive during a read
// response.
module crc_reg_target
    import crc_reg_pkg::*;
#(
    parameter int         NUM_REGS = 40,
    parameter logic [7:0] POLY     = 8'h07
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sof,
    input  logic       eof,
    input  logic       byte_vld,
    input  logic [7:0] byte_in,
    input  logic       err_clr,
    output logic       rd_vld,
    output logic [7:0] rd_data,
    output logic       crc_err,
    output logic       len_err,
    output logic       addr_err
);
    fstate_t                      state;
    logic                         is_rd;
    logic [ADDR_W-1:0]            base;
    logic [LEN_W-1:0]             last;
    logic [LEN_W-1:0]             cnt;
    logic [LEN_W:0]               tx_idx;
    logic                         range_ok;
    logic [MAX_BURST-1:0][7:0]    stage;
    logic [7:0]                   crc_q;
    logic [7:0]                   reg_rd;
    logic [ADDR_W-1:0]            rd_addr;

    logic fstart, rx, hdr_ok, mid, tx_data;
    logic commit, crc_set, len_set, addr_set, crc_en;
    logic [7:0] crc_din;

    // Decode strobes for the current cycle.
    always_comb begin
        fstart   = sof && byte_vld;
        rx       = byte_vld && !sof;
        mid      = (state == ST_HDR) || (state == ST_WDATA) || (state == ST_WCRC);
        hdr_ok   = (NUM_REGS >= 64) ||
                   ((int'(byte_in[ADDR_W-1:0]) + int'(byte_in[7:ADDR_W])) < NUM_REGS);
        tx_data  = (state == ST_TX) && (tx_idx <= {1'b0, last});
        commit   = (state == ST_WCRC) && rx && (byte_in == crc_q) && range_ok;
        crc_set  = (state == ST_WCRC) && rx && (byte_in != crc_q);
        len_set  = (eof || fstart) && mid;
        addr_set = (state == ST_HDR) && rx && !hdr_ok;
        crc_en   = fstart || (rx && ((state == ST_HDR) || (state == ST_WDATA))) || tx_data;
        crc_din  = (tx_data && !fstart) ? reg_rd : byte_in;
        rd_addr  = base + {{(ADDR_W-LEN_W){1'b0}}, tx_idx[LEN_W-1:0]};
        rd_vld   = (state == ST_TX);
        rd_data  = tx_data ? reg_rd : crc_q;
    end

    // Walk the frame: header, write data and CRC, or read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            is_rd    <= 1'b0;
            base     <= '0;
            last     <= '0;
            cnt      <= '0;
            tx_idx   <= '0;
            range_ok <= 1'b0;
            stage    <= '0;
        end else if (fstart) begin
            is_rd <= byte_in[0];
            state <= ST_HDR;
        end else if (eof && state != ST_TX) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_HDR: if (byte_vld) begin
                    base     <= byte_in[ADDR_W-1:0];
                    last     <= byte_in[7:ADDR_W];
                    range_ok <= hdr_ok;
                    cnt      <= '0;
                    tx_idx   <= '0;
                    if (is_rd) state <= hdr_ok ? ST_TX : ST_DONE;
                    else       state <= ST_WDATA;
                end
                ST_WDATA: if (byte_vld) begin
                    stage[cnt] <= byte_in;
                    cnt        <= cnt + 1'b1;
                    if (cnt == last) state <= ST_WCRC;
                end
                ST_WCRC: if (byte_vld) state <= ST_DONE;
                ST_TX: begin
                    tx_idx <= tx_idx + 1'b1;
                    if (tx_idx == {1'b0, last} + 1'b1) state <= ST_DONE;
                end
                default: ;
            endcase
        end
    end

    // Sticky error flags: set on events, cleared by err_clr.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_err  <= 1'b0;
            len_err  <= 1'b0;
            addr_err <= 1'b0;
        end else begin
            crc_err  <= (crc_err  && !err_clr) || crc_set;
            len_err  <= (len_err  && !err_clr) || len_set;
            addr_err <= (addr_err && !err_clr) || addr_set;
        end
    end

    crc8_acc #(.POLY(POLY)) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (fstart),
        .en    (crc_en),
        .din   (crc_din),
        .crc   (crc_q)
    );

    reg_store #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit),
        .wr_base (base),
        .wr_last (last),
        .wr_data (stage),
        .rd_addr (rd_addr),
        .rd_data (reg_rd)
    );

    // R5
    crc_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err && !err_clr |=> crc_err);

    // R7
    len_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(len_err) |-> $past(eof || sof));

    // R6
    resp_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_vld) |-> $past(byte_vld));

    // R9
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr && !byte_vld && !eof && !sof |=> !crc_err && !len_err && !addr_err);
endmodule

// File: tb/sim_crc_reg_target.sv
`timescale 1ns/1ps
module sim_crc_reg_target;
    logic       clk = 1'b0;
    logic       rst_n, sof, eof, byte_vld, err_clr;
    logic [7:0] byte_in;
    logic       rd_vld, crc_err, len_err, addr_err;
    logic [7:0] rd_data;

    int vectors = 0;
    int errs    = 0;
    int seen    = 0;
    logic [7:0] expq[$];
    logic [7:0] mdl[64];

    localparam logic [7:0] WA = {7'h2D, 1'b0};
    localparam logic [7:0] RA = {7'h2D, 1'b1};
    localparam int NREG = 40;

    always #10 clk = ~clk;

    crc_reg_target u0 (
        .clk(clk), .rst_n(rst_n), .sof(sof), .eof(eof), .byte_vld(byte_vld),
        .byte_in(byte_in), .err_clr(err_clr), .rd_vld(rd_vld), .rd_data(rd_data),
        .crc_err(crc_err), .len_err(len_err), .addr_err(addr_err)
    );

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Bit-serial reference CRC (poly 0x07, MSB first).
    function automatic logic [7:0] bcrc(input logic [7:0] c, input logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            logic fb;
            fb = c[7] ^ d[i];
            c  = {c[6:0], 1'b0};
            if (fb) c = c ^ 8'h07;
        end
        return c;
    endfunction

    // Monitor: compare every response byte against the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n && rd_vld) begin
            seen++;
            if (expq.size() == 0) check("R6 unexpected response byte", 1, 0);
            else check("R6 R3 response byte", rd_data, expq.pop_front());
        end
    end

    task automatic put(input logic [7:0] b, input logic s);
        byte_vld = 1'b1; byte_in = b; sof = s;
        @(negedge clk);
        byte_vld = 1'b0; sof = 1'b0;
    endtask

    task automatic endf();
        eof = 1'b1;
        @(negedge clk);
        eof = 1'b0;
        @(negedge clk);
    endtask

    task automatic clr();
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [1:0] lm1,
                      input logic [31:0] d, input bit bad);
        logic [7:0] rb, c;
        rb = {lm1, a};
        c  = bcrc(bcrc(8'h00, WA), rb);
        put(WA, 1'b1);
        put(rb, 1'b0);
        for (int k = 0; k <= int'(lm1); k++) begin
            c = bcrc(c, d[8*k +: 8]);
            put(d[8*k +: 8], 1'b0);
        end
        put(bad ? ~c : c, 1'b0);
        put(8'hC3, 1'b0);
        endf();
        if (!bad && (int'(a) + int'(lm1) < NREG))
            for (int k = 0; k <= int'(lm1); k++) mdl[(int'(a) + k) % 64] = d[8*k +: 8];
    endtask

    task automatic rd(input logic [5:0] a, input logic [1:0] lm1, input bit resp);
        logic [7:0] rb, c;
        rb = {lm1, a};
        c  = bcrc(bcrc(8'h00, RA), rb);
        if (resp) begin
            for (int k = 0; k <= int'(lm1); k++) begin
                expq.push_back(mdl[(int'(a) + k) % 64]);
                c = bcrc(c, mdl[(int'(a) + k) % 64]);
            end
            expq.push_back(c);
        end
        put(RA, 1'b1);
        put(rb, 1'b0);
        repeat (6) @(negedge clk);
        endf();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check("watchdog expired", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

    initial begin
        int s0;
        for (int i = 0; i < 64; i++) mdl[i] = 8'h00;
        rst_n = 1'b0; sof = 0; eof = 0; byte_vld = 0; err_clr = 0; byte_in = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 crc_err", crc_err, 0);
        check("R1 len_err", len_err, 0);
        check("R1 addr_err", addr_err, 0);
        check("R1 rd_vld", rd_vld, 0);
        rd(6'd0, 2'b11, 1'b1);              // R1 zeros plus R6 CRC
        // R2 R4 R10 single and multi-byte writes
        wr(6'd5, 2'b00, 32'h000000A5, 1'b0);
        rd(6'd5, 2'b00, 1'b1);
        wr(6'd10, 2'b11, 32'h44332211, 1'b0);
        rd(6'd10, 2'b11, 1'b1);
        rd(6'd11, 2'b01, 1'b1);
        wr(6'd20, 2'b10, 32'h00C0FFEE, 1'b0);
        rd(6'd19, 2'b11, 1'b1);
        check("R4 no flags after clean writes", {crc_err, len_err, addr_err}, 0);
        // R5 corrupted CRC: no change, sticky flag
        wr(6'd10, 2'b10, 32'h00ABCDEF, 1'b1);
        check("R5 crc_err set", crc_err, 1);
        rd(6'd10, 2'b11, 1'b1);
        repeat (3) @(negedge clk);
        check("R5 crc_err sticky", crc_err, 1);
        // R9 clear
        clr();
        check("R9 crc_err cleared", crc_err, 0);
        // R7 truncated write by eof
        put(WA, 1'b1); put({2'b10, 6'd30}, 1'b0); put(8'h11, 1'b0); put(8'h22, 1'b0);
        endf();
        check("R7 len_err on eof", len_err, 1);
        rd(6'd30, 2'b10, 1'b1);
        clr();
        check("R9 len_err cleared", len_err, 0);
        // R7 truncated write by new frame start, then read proceeds
        put(WA, 1'b1); put({2'b01, 6'd31}, 1'b0); put(8'h5A, 1'b0);
        rd(6'd31, 2'b01, 1'b1);
        check("R7 len_err on new sof", len_err, 1);
        clr();
        // R8 out-of-range write and read
        wr(6'd38, 2'b11, 32'h99887766, 1'b0);
        check("R8 addr_err on write", addr_err, 1);
        check("R8 no crc_err", crc_err, 0);
        rd(6'd36, 2'b11, 1'b1);
        clr();
        check("R9 addr_err cleared", addr_err, 0);
        s0 = seen;
        rd(6'd39, 2'b01, 1'b0);
        check("R8 no read response", seen, s0);
        check("R8 addr_err on read", addr_err, 1);
        clr();
        rd(6'd39, 2'b00, 1'b1);             // R8 last populated register is legal
        check("R8 edge access clean", addr_err, 0);
        // R4 bytes after the dummy are ignored
        wr(6'd2, 2'b00, 32'h0000007E, 1'b0);
        put(WA, 1'b1); put({2'b00, 6'd2}, 1'b0); put(8'h7E, 1'b0);
        put(bcrc(bcrc(bcrc(8'h00, WA), {2'b00, 6'd2}), 8'h7E), 1'b0);
        put(8'h01, 1'b0); put(8'h02, 1'b0); put(8'h03, 1'b0);
        endf();
        rd(6'd0, 2'b11, 1'b1);
        check("R4 no flags", {crc_err, len_err, addr_err}, 0);
        repeat (4) @(negedge clk);
        check("R6 scoreboard drained", expq.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end
endmodule